// File: doc/BRIEF.md
# GPIO Interrupt Style Detector

This block watches sixteen general-purpose input pins and raises one interrupt request per pin. Each pin has a three-bit style field that selects what counts as an event. The choices are a high level, a low level, a rising edge, a falling edge, or either edge. Any other code turns detection off for that pin. The style fields are packed eight to a word into two configuration words.

A detected event sets a sticky pending flag for that pin, and the flag drives the pin's interrupt output straight to a downstream interrupt controller. Software clears a flag by writing a one to its bit in the status word. A level-style source that is still active keeps its flag set, whatever is written. When a pin's style field is rewritten to a different value, its pending flag is dropped in the same cycle, so an event detected under the old style is never reported.

Pins enter through a two-flop synchroniser. Edge detection compares the synchronised value with its value one cycle earlier. A simple single-cycle register port gives write access and combinational read access to the two style words and the status word.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every style field is 0, every pending flag is 0 and irq_o is 0. Reading address 0, 1 or 2 returns 0.
- R2: irq_o[p] always equals pin p's pending flag. Reading address 2 returns the flags in bits 15:0 and zeros above. Address 3 reads 0.
- R3: Pin p's style field is bits [(p mod 8)*3 +: 3] of the style word at address p/8 (pins 0-7 at address 0, pins 8-15 at address 1). A write stores it and a read returns it, with bits 31:24 reading 0.
- R4: Style 0 (high level) sets the flag in every cycle in which the synchronised pin is 1.
- R5: Style 1 (low level) sets the flag in every cycle in which the synchronised pin is 0.
- R6: Style 2 (rising edge) sets the flag on a 0-to-1 change of the synchronised pin. The flag stays set after the pin returns to 0.
- R7: Style 3 (falling edge) sets the flag on a 1-to-0 change of the synchronised pin.
- R8: Style 4 (either edge) sets the flag on any change of the synchronised pin.
- R9: Style codes 5, 6 and 7 never set the flag.
- R10: A write to address 2 clears each flag whose wdata bit is 1. Bits written as 0 leave their flags unchanged.
- R11: While a level-style condition holds, a clear write does not drop that pin's flag.
- R12: An edge event in the same cycle as a clear write of that pin leaves the flag set.
- R13: A style write that changes a pin's field clears that pin's flag at that clock edge. Pins whose field is unchanged keep their flags.
- R14: A pin change applied just after a rising clock edge can affect irq_o no earlier than after the third following rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 16 | Asynchronous GPIO input pins |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 2 | Register address: 0 and 1 style words, 2 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| irq_o | output | 16 | Per-pin interrupt requests (pending flags) |

## Verification
Three things can land on the same clock edge for one pin: a new detection, a clear write to the status word, and a style rewrite. Directed cases time a clear write so that it is sampled on the edge where a rising-edge event sets the flag. Other directed cases issue clear writes while a level condition holds, and rewrite a style while its flag is pending. The flag must survive the first two cases and drop in the third. Random pin toggles mixed with random style and clear writes reach further such collisions, and each one is judged every cycle against a bench-side cycle model of the synchroniser, the styles and the flag priorities.

// File: rtl/gpio_det_pkg.sv
package gpio_det_pkg;
  localparam int STYLE_W = 3;

  localparam logic [STYLE_W-1:0] STY_HIGH = 3'd0;
  localparam logic [STYLE_W-1:0] STY_LOW  = 3'd1;
  localparam logic [STYLE_W-1:0] STY_RISE = 3'd2;
  localparam logic [STYLE_W-1:0] STY_FALL = 3'd3;
  localparam logic [STYLE_W-1:0] STY_BOTH = 3'd4;

  // Does the synchronised sample pair satisfy the given style?
  function automatic logic style_hit(logic [STYLE_W-1:0] sty, logic cur, logic prv);
    logic r;
    case (sty)
      STY_HIGH: r = cur;
      STY_LOW:  r = ~cur;
      STY_RISE: r = cur & ~prv;
      STY_FALL: r = ~cur & prv;
      STY_BOTH: r = cur ^ prv;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

  // Bit offset of a pin's field inside its style word
  function automatic int field_lsb(int pin, int pins_per_word);
    return (pin % pins_per_word) * STYLE_W;
  endfunction

  // Which style word holds a pin
  function automatic int word_of(int pin, int pins_per_word);
    return pin / pins_per_word;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_o  <= '0;
      prev_o <= '0;
    end else begin
      meta_q <= pin_i;
      cur_o  <= meta_q;
      prev_o <= cur_o;
    end
  end

  // R14
  sync_stage2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cur_o == $past(meta_q)));

  // R14
  sync_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prev_o == $past(cur_o)));
endmodule

// File: rtl/gpio_style_bank.sv
module gpio_style_bank
  import gpio_det_pkg::*;
#(
  parameter int N      = 16,
  parameter int PPW    = 8,
  parameter int DATA_W = 32,
  parameter int NW     = 2,
  parameter int ADDR_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [STYLE_W-1:0]     style_o [N],
  output logic [N-1:0]           chg_o,
  output logic [NW*DATA_W-1:0]   words_o
);
  logic [N-1:0] sel;

  for (genvar p = 0; p < N; p++) begin : g_pin
    localparam int W   = word_of(p, PPW);
    localparam int LSB = field_lsb(p, PPW);
    logic [STYLE_W-1:0] nxt;

    assign sel[p]   = wr_en && (addr == ADDR_W'(W));
    assign nxt      = wdata[LSB +: STYLE_W];
    assign chg_o[p] = sel[p] && (nxt != style_o[p]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      style_o[p] <= '0;
      else if (sel[p]) style_o[p] <= nxt;
    end

    // R3
    style_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel[p] |=> $stable(style_o[p]));
  end

  always_comb begin
    words_o = '0;
    for (int p = 0; p < N; p++)
      words_o[word_of(p, PPW)*DATA_W + field_lsb(p, PPW) +: STYLE_W] = style_o[p];
  end
endmodule

// File: rtl/gpio_edge_level.sv
module gpio_edge_level
  import gpio_det_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [STYLE_W-1:0] style_i [N],
  input  logic [N-1:0]       cur_i,
  input  logic [N-1:0]       prev_i,
  output logic [N-1:0]       hit_o
);
  for (genvar p = 0; p < N; p++) begin : g_det
    assign hit_o[p] = style_hit(style_i[p], cur_i[p], prev_i[p]);
  end
endmodule

// File: rtl/gpio_pend_status.sv
module gpio_pend_status #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] chg_i,
  output logic [N-1:0] pend_o
);
  // Priority: style change clears, then detection sets, then W1C clears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= ((pend_o & ~clr_i) | hit_i) & ~chg_i;
  end

  // R10
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~hit_i)) |=> ((pend_o & $past(clr_i & ~hit_i)) == '0));

  // R10
  zero_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_o & ~clr_i & ~chg_i)) |=>
      ((pend_o & $past(pend_o & ~clr_i & ~chg_i)) == $past(pend_o & ~clr_i & ~chg_i)));

  // R12
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit_i & ~chg_i)) |=> ((pend_o & $past(hit_i & ~chg_i)) == $past(hit_i & ~chg_i)));

  // R13
  style_change_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg_i) |=> ((pend_o & $past(chg_i)) == '0));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_det_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int PPW      = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [NUM_PINS-1:0] irq_o
);
  localparam int NW        = (NUM_PINS + PPW - 1) / PPW;
  localparam int STAT_ADDR = NW;

  logic [NUM_PINS-1:0]  cur, prev, hit, clr, chg, pend;
  logic [STYLE_W-1:0]   style [NUM_PINS];
  logic [NW*DATA_W-1:0] words;
  logic                 stat_wr;

  gpio_in_sync #(.N(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cur_o(cur), .prev_o(prev)
  );

  gpio_style_bank #(.N(NUM_PINS), .PPW(PPW), .DATA_W(DATA_W), .NW(NW), .ADDR_W(ADDR_W)) u_style (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .style_o(style), .chg_o(chg), .words_o(words)
  );

  gpio_edge_level #(.N(NUM_PINS)) u_det (
    .style_i(style), .cur_i(cur), .prev_i(prev), .hit_o(hit)
  );

  assign stat_wr = wr_en && (addr == ADDR_W'(STAT_ADDR));
  assign clr     = stat_wr ? wdata[NUM_PINS-1:0] : '0;

  gpio_pend_status #(.N(NUM_PINS)) u_pend (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .clr_i(clr), .chg_i(chg), .pend_o(pend)
  );

  assign irq_o = pend;

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NW; w++)
      if (addr == ADDR_W'(w)) rdata = words[w*DATA_W +: DATA_W];
    if (addr == ADDR_W'(STAT_ADDR)) rdata[NUM_PINS-1:0] = pend;
  end

  // R9
  disabled_style_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~hit & ~pend)) |=> ((irq_o & $past(~hit & ~pend)) == '0));
endmodule

// File: tb/test_gpio_irq_detect.sv
`timescale 1ns/1ps
module test_gpio_irq_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin_i = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] irq_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_detect i_gpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  // Bench reference model, written from the requirements
  logic [15:0] m_s1, m_s2, m_pv, m_pend;
  logic [2:0]  m_sty [16];

  function automatic logic ref_hit(logic [2:0] s, logic c, logic p);
    if (s == 3'd0) return c;
    if (s == 3'd1) return !c;
    if (s == 3'd2) return c && !p;
    if (s == 3'd3) return p && !c;
    if (s == 3'd4) return c != p;
    return 1'b0;
  endfunction

  function automatic logic [31:0] ref_read(logic [1:0] a);
    logic [31:0] r = '0;
    if (a == 2'd2) r[15:0] = m_pend;
    else if (a != 2'd3)
      for (int k = 0; k < 8; k++) r[k*3 +: 3] = m_sty[a*8 + k];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [15:0] h, c, g;
    logic [2:0]  nv;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_pv = '0; m_pend = '0;
      for (int k = 0; k < 16; k++) m_sty[k] = '0;
    end else begin
      h = '0; c = '0; g = '0;
      for (int k = 0; k < 16; k++) h[k] = ref_hit(m_sty[k], m_s2[k], m_pv[k]);
      if (wr_en && addr == 2'd2) c = wdata[15:0];
      if (wr_en && addr < 2'd2)
        for (int k = 0; k < 8; k++) begin
          nv = wdata[k*3 +: 3];
          if (nv != m_sty[addr*8 + k]) g[addr*8 + k] = 1'b1;
          m_sty[addr*8 + k] = nv;
        end
      m_pend = ((m_pend & ~c) | h) & ~g;
      m_pv = m_s2; m_s2 = m_s1; m_s1 = pin_i;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #2;
      chk("R2 irq_o vs model", {16'h0, irq_o}, {16'h0, m_pend});
      chk("R2 rdata vs model", rdata, ref_read(addr));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    cyc(1);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(string tag, logic [1:0] a, logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    cyc(3);
    chk("R1 irq after reset", {16'h0, irq_o}, 32'h0);
    rd("R1 read style0", 2'd0, 32'h0);
    rd("R1 read style1", 2'd1, 32'h0);
    rd("R1 read status", 2'd2, 32'h0);
    rst_n = 1'b1;
    cyc(2);

    // R14 and R4: pin 5 high under default high-level style
    pin_i[5] = 1'b1;
    cyc(2);
    chk("R14 latency not before third edge", {31'h0, irq_o[5]}, 32'h0);
    cyc(1);
    chk("R4 high level sets flag", {31'h0, irq_o[5]}, 32'h1);
    wr(2'd2, 32'h20);
    chk("R11 level survives clear", {31'h0, irq_o[5]}, 32'h1);
    pin_i[5] = 1'b0;
    cyc(3);
    wr(2'd2, 32'h20);
    chk("R10 clear after level gone", {31'h0, irq_o[5]}, 32'h0);

    // R3: pin 9 rising style at bits 5:3 of word 1
    wr(2'd1, 32'h10);
    rd("R3 style word 1 readback", 2'd1, 32'h10);
    rd("R2 status reads zero", 2'd2, 32'h0);
    wr(2'd1, 32'hFF00_0010);
    rd("R3 upper bits read zero", 2'd1, 32'h10);

    // R6: rising edge, sticky
    pin_i[9] = 1'b1;
    cyc(3);
    chk("R6 rising sets flag", {31'h0, irq_o[9]}, 32'h1);
    pin_i[9] = 1'b0;
    cyc(3);
    chk("R6 flag sticky after fall", {31'h0, irq_o[9]}, 32'h1);
    wr(2'd2, 32'hFFFF_FDFF);
    chk("R10 zero bit leaves flag", {31'h0, irq_o[9]}, 32'h1);
    wr(2'd2, 32'h200);
    chk("R10 one bit clears flag", {31'h0, irq_o[9]}, 32'h0);
    cyc(2);
    chk("R6 falling ignored by rising style", {31'h0, irq_o[9]}, 32'h0);

    // R12: edge event sampled on the same edge as a clear write
    pin_i[9] = 1'b1;
    cyc(2);
    wr(2'd2, 32'h200);
    chk("R12 event beats clear", {31'h0, irq_o[9]}, 32'h1);

    // R13: changing the style drops the pending flag
    wr(2'd1, 32'h18);
    chk("R13 style change clears flag", {31'h0, irq_o[9]}, 32'h0);
    pin_i[9] = 1'b0;
    cyc(3);
    chk("R7 falling sets flag", {31'h0, irq_o[9]}, 32'h1);
    wr(2'd1, 32'h18);
    chk("R13 same value keeps flag", {31'h0, irq_o[9]}, 32'h1);

    // R8: both edges
    wr(2'd1, 32'h20);
    pin_i[9] = 1'b1;
    cyc(3);
    chk("R8 rise sets flag", {31'h0, irq_o[9]}, 32'h1);
    wr(2'd2, 32'h200);
    chk("R8 cleared", {31'h0, irq_o[9]}, 32'h0);
    pin_i[9] = 1'b0;
    cyc(3);
    chk("R8 fall sets flag", {31'h0, irq_o[9]}, 32'h1);

    // R5: low level on pin 2 (bits 8:6 of word 0)
    wr(2'd0, 32'h40);
    cyc(1);
    chk("R5 low level sets flag", {31'h0, irq_o[2]}, 32'h1);
    pin_i[2] = 1'b1;
    cyc(3);
    wr(2'd2, 32'h4);
    chk("R5 clear once pin high", {31'h0, irq_o[2]}, 32'h0);

    // R9: disabled code
    wr(2'd1, 32'h38);
    pin_i[9] = 1'b1;
    cyc(3);
    pin_i[9] = 1'b0;
    cyc(3);
    chk("R9 disabled style never sets", {31'h0, irq_o[9]}, 32'h0);
    rd("R3 disabled code reads back", 2'd1, 32'h38);
    rd("R2 unused address reads zero", 2'd3, 32'h0);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      pin_i = pin_i ^ 16'($urandom & $urandom & $urandom);
      if (($urandom % 6) == 0) begin
        wr_en = 1'b1;
        addr  = 2'($urandom);
        wdata = $urandom;
      end else begin
        wr_en = 1'b0;
        addr  = 2'($urandom);
      end
      cyc(1);
    end
    wr_en = 1'b0;
    cyc(1);

    done = 1'b1;
    #3;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule